// File: doc/BRIEF.md
# Two-Phase Latched FIFO Queue

A first-in first-out queue, 16 words deep and 8 bits wide by default, built from level-sensitive latches and run by a two-phase non-overlapping clock. While `phi1_i` is high, transparent latches take in the read request, the write request and the input word. While `phi2_i` is high, the queue state is updated and a second set of latches captures the full flag, the empty flag and the output word. A consumer can therefore sample these outputs safely during the next `phi1_i` pulse.

Stored words never move between rows. Two circulating one-hot token rings mark the rows in use. The tail ring selects the row that a write fills. The head ring selects the row shown on the output. When the two tokens sit on the same row, the queue could be either full or empty, so a single lap bit tells the two cases apart. Each storage row is a word of replicated one-bit latch cells.

Top module: `biphase_fifo`

## Requirements
- R1: While `rst_ni` is low, `empty_o` is 1, `full_o` is 0 and `data_o` is 0. After release, both tokens start at row 0 and the queue is empty.
- R2: Inputs take effect in the phi1 phase of a cycle. The outputs change only while `phi2_i` is high, so values read after phi2 falls are unchanged during the following phi1 pulse.
- R3: Words leave the queue in the order they were written. When the queue is not empty, `data_o` shows the oldest stored word.
- R4: After 16 net writes `full_o` is 1. A write while full is ignored: the occupancy and the stored words stay as they were.
- R5: A read while empty is ignored. `empty_o` stays 1 and a later write is read back correctly.
- R6: A read and a write in the same cycle on a queue that is neither full nor empty do both operations, and the occupancy does not change.
- R7: `full_o` and `empty_o` are never 1 at the same time.
- R8: The head and tail rings each hold exactly one token at all times.
- R9: The tokens wrap from the last row back to row 0 without loss of order, over many laps.
- R10: A read and a write in the same cycle on an empty queue perform only the write. On a full queue they perform only the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi1_i | input | 1 | Phase-1 clock; input latches are open while high |
| phi2_i | input | 1 | Phase-2 clock; state and output latches are open while high |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read request: drop the head word |
| wr_i | input | 1 | Write request: store `data_i` at the tail |
| data_i | input | 8 | Word to write |
| full_o | output | 1 | Queue holds 16 words |
| empty_o | output | 1 | Queue holds no words |
| data_o | output | 8 | Word at the head of the queue |

## Verification
The bench builds the queue with its default 16 rows of 8 bits. At this size, a full lap of both token rings takes only a few dozen cycles, so several hundred cycles of mixed traffic drive each ring around many times. This covers the lap-bit transitions on both the full side and the empty side, and the refused operations at both ends. A behavioural queue model is compared against the flags and the head word after every phi2 pulse. The outputs are also checked again during the next phi1 pulse to confirm that they hold.

// File: rtl/biphase_fifo_pkg.sv
package biphase_fifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/biphase_bit_cell.sv
module biphase_bit_cell (
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_latch begin
    if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/biphase_word_reg.sv
module biphase_word_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    biphase_bit_cell i_cell (
      .en_i (en_i),
      .d_i  (d_i[b]),
      .q_o  (q_o[b])
    );
  end
endmodule

// File: rtl/biphase_ring.sv
// One-hot token ring: phi2 latch holds the next token, phi1 latch holds the
// current token seen by the control logic during phi2.
module biphase_ring #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             phi1_i,
  input  logic             phi2_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [DEPTH-1:0] cur_o,
  output logic [DEPTH-1:0] adv_o,
  output logic [DEPTH-1:0] nxt_o
);
  localparam logic [DEPTH-1:0] HomeTok = DEPTH'(1);

  assign adv_o = {cur_o[DEPTH-2:0], cur_o[DEPTH-1]};

  always_latch begin
    if (!rst_ni)     nxt_o <= HomeTok;
    else if (phi2_i) nxt_o <= step_i ? adv_o : cur_o;
  end

  always_latch begin
    if (!rst_ni)     cur_o <= HomeTok;
    else if (phi1_i) cur_o <= nxt_o;
  end

  // R8
  a_r8_token_onehot: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    $countones(nxt_o) == 1);
endmodule

// File: rtl/biphase_fifo.sv
module biphase_fifo
  import biphase_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic             phi1_i,
  input  logic             phi2_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [WIDTH-1:0] data_o
);
  // phi1 input latches
  logic             rd_q1, wr_q1;
  logic [WIDTH-1:0] din_q1;

  always_latch begin
    if (!rst_ni) begin
      rd_q1  <= 1'b0;
      wr_q1  <= 1'b0;
      din_q1 <= '0;
    end else if (phi1_i) begin
      rd_q1  <= rd_i;
      wr_q1  <= wr_i;
      din_q1 <= data_i;
    end
  end

  logic [DEPTH-1:0] head_cur, head_adv, head_nxt;
  logic [DEPTH-1:0] tail_cur, tail_adv, tail_nxt;
  logic             lap_q1, lap_q2, lap_d;
  logic             tok_eq, is_full, is_empty, do_wr, do_rd;
  fifo_op_e         op;

  assign tok_eq   = (head_cur == tail_cur);
  assign is_full  = tok_eq &  lap_q1;
  assign is_empty = tok_eq & ~lap_q1;
  assign do_wr    = wr_q1 & ~is_full;
  assign do_rd    = rd_q1 & ~is_empty;
  assign op       = fifo_op_e'({do_rd, do_wr});

  biphase_ring #(.DEPTH(DEPTH)) i_head_ring (
    .phi1_i (phi1_i),
    .phi2_i (phi2_i),
    .rst_ni (rst_ni),
    .step_i (do_rd),
    .cur_o  (head_cur),
    .adv_o  (head_adv),
    .nxt_o  (head_nxt)
  );

  biphase_ring #(.DEPTH(DEPTH)) i_tail_ring (
    .phi1_i (phi1_i),
    .phi2_i (phi2_i),
    .rst_ni (rst_ni),
    .step_i (do_wr),
    .cur_o  (tail_cur),
    .adv_o  (tail_adv),
    .nxt_o  (tail_nxt)
  );

  // Lap bit: set when a lone write closes the gap, cleared when a lone read does.
  always_comb begin
    unique case (op)
      OP_PUSH: lap_d = lap_q1 | (tail_adv == head_cur);
      OP_POP:  lap_d = lap_q1 & (head_adv != tail_cur);
      default: lap_d = lap_q1;
    endcase
  end

  always_latch begin
    if (!rst_ni)     lap_q2 <= 1'b0;
    else if (phi2_i) lap_q2 <= lap_d;
  end

  always_latch begin
    if (!rst_ni)     lap_q1 <= 1'b0;
    else if (phi1_i) lap_q1 <= lap_q2;
  end

  // Storage array: rows written in phi2 at the tail token.
  logic [WIDTH-1:0] row_q [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    biphase_word_reg #(.WIDTH(WIDTH)) i_row (
      .en_i (phi2_i & do_wr & tail_cur[r]),
      .d_i  (din_q1),
      .q_o  (row_q[r])
    );
  end

  logic [WIDTH-1:0] head_word;
  always_comb begin
    head_word = '0;
    for (int r = 0; r < DEPTH; r++) begin
      if (head_nxt[r]) head_word = head_word | row_q[r];
    end
  end

  // phi2 output latches
  always_latch begin
    if (!rst_ni) begin
      full_o  <= 1'b0;
      empty_o <= 1'b1;
      data_o  <= '0;
    end else if (phi2_i) begin
      full_o  <= (head_nxt == tail_nxt) &  lap_q2;
      empty_o <= (head_nxt == tail_nxt) & ~lap_q2;
      data_o  <= head_word;
    end
  end

  // R7
  a_r7_not_full_and_empty: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  // R4
  a_r4_full_holds: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    ($past(full_o) && !rd_q1) |-> full_o);
  // R5
  a_r5_empty_holds: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    ($past(empty_o) && !wr_q1) |-> empty_o);
  // R6
  a_r6_both_keeps_level: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    (!$past(full_o) && !$past(empty_o) && rd_q1 && wr_q1) |->
      ($stable(full_o) && $stable(empty_o)));
  // R10
  a_r10_both_on_empty_writes: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    ($past(empty_o) && rd_q1 && wr_q1) |-> !empty_o);
endmodule

// File: tb/test_biphase_fifo.sv
module test_biphase_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  logic             phi1, phi2, rst_n, rd, wr;
  logic [WIDTH-1:0] din;
  logic             full, empty;
  logic [WIDTH-1:0] dout;

  int checks = 0;
  int errors = 0;
  int model[$];
  logic [15:0] lfsr = 16'hACE1;

  biphase_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_biphase_fifo (
    .phi1_i (phi1), .phi2_i (phi2), .rst_ni (rst_n),
    .rd_i (rd), .wr_i (wr), .data_i (din),
    .full_o (full), .empty_o (empty), .data_o (dout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One 20 ns (50 MHz) cycle: phi1 2..8 ns, phi2 12..18 ns.
  task automatic cycle(input logic r, input logic w, input logic [WIDTH-1:0] d,
                       input string req);
    logic pf, pe;
    logic [WIDTH-1:0] pd;
    pf = full; pe = empty; pd = dout;
    rd = r; wr = w; din = d;
    #2 phi1 = 1'b1;
    #3;
    if (rst_n) begin
      chk("R2 full held in phi1", int'(full), int'(pf));
      chk("R2 empty held in phi1", int'(empty), int'(pe));
      chk("R2 data held in phi1", int'(dout), int'(pd));
    end
    #3 phi1 = 1'b0;
    #4 phi2 = 1'b1;
    #6 phi2 = 1'b0;
    #2;
    if (rst_n) begin
      bit was_full, was_empty;
      was_full  = (model.size() == DEPTH);
      was_empty = (model.size() == 0);
      if (r && !was_empty) void'(model.pop_front());
      if (w && !was_full) model.push_back(int'(d));
      chk({req, " empty"}, int'(empty), int'(model.size() == 0));
      chk({req, " full"}, int'(full), int'(model.size() == DEPTH));
      if (model.size() != 0) chk({req, " head word"}, int'(dout), model[0]);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    phi1 = 0; phi2 = 0; rst_n = 0; rd = 0; wr = 0; din = '0;
    cycle(1'b0, 1'b1, 8'h55, "R1");
    cycle(1'b1, 1'b1, 8'hAA, "R1");
    chk("R1 empty in reset", int'(empty), 1);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 data in reset", int'(dout), 0);
    rst_n = 1;
    cycle(1'b0, 1'b0, 8'h00, "R1 after release");
    // R5: read while empty, then write is returned correctly
    cycle(1'b1, 1'b0, 8'h00, "R5 read on empty");
    cycle(1'b1, 1'b0, 8'h00, "R5 read on empty");
    // R10: both on empty performs only the write
    cycle(1'b1, 1'b1, 8'h3C, "R10 both on empty");
    cycle(1'b1, 1'b0, 8'h00, "R5 drain");
    // R3/R4: fill to 16, then writes while full
    for (int i = 0; i < DEPTH; i++) cycle(1'b0, 1'b1, 8'(8'h10 + i), "R3 fill");
    chk("R4 full after 16", int'(full), 1);
    cycle(1'b0, 1'b1, 8'hEE, "R4 write on full");
    cycle(1'b0, 1'b1, 8'hEF, "R4 write on full");
    // R10: both on full performs only the read
    cycle(1'b1, 1'b1, 8'hDD, "R10 both on full");
    cycle(1'b1, 1'b1, 8'h77, "R6 both mid");
    for (int i = 0; i < DEPTH + 2; i++) cycle(1'b1, 1'b0, 8'h00, "R3 drain order");
    chk("R5 empty after drain", int'(empty), 1);
    // R6/R9: mixed traffic over many laps
    for (int i = 0; i < 600; i++) begin
      logic r, w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[0] | (lfsr[5] & lfsr[6]);
      w = lfsr[1] | lfsr[7];
      if (i >= 300) begin r = lfsr[0] | lfsr[3]; w = lfsr[2]; end
      cycle(r, w, lfsr[15:8], "R9 mixed traffic");
    end
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 8'(i * 7), "R6 steady both");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule